// File: doc/BRIEF.md
# Pseudorandom Pattern Bit Error Rate Tester

This block measures the bit error rate of a serial link, handling one bit for each cycle in which its bit strobe is high. It sends a maximal-length pseudorandom sequence on its transmit output and expects the same sequence back on its receive input. Transmit and receive run at the same time, in full duplex. Four sequence lengths are available: 63, 511, 2047 and 4095 bits.

The receiver does not know the phase of the returned stream. It aligns itself by loading incoming bits straight into a local reference register. It then predicts each following bit and declares lock after a run of correct predictions. While locked it keeps two cumulative totals, bits received and bits in error. Software divides the second by the first to get the error rate. If errors come too densely, lock is dropped, both totals freeze, and the receiver hunts again. A start pulse clears the totals, selects the pattern and restarts the hunt.

Top module: `pn_bert`

## Requirements
- R1: The pattern code on `patSel` is captured on `start` and is ignored at other times. Each transmitted bit t(n) satisfies a recurrence that depends on the code. Code 0 gives a 63-bit sequence with t(n)=t(n-6)^t(n-5). Code 1 gives 511 bits with t(n)=t(n-9)^t(n-5). Code 2 gives 2047 bits with t(n)=t(n-11)^t(n-9). Code 3 gives 4095 bits with t(n)=t(n-12)^t(n-6)^t(n-4)^t(n-1). The sequence is never all zeros.
- R2: In a cycle where `bitEn` is low and `start` is low, `txBit`, `inSync` and both counters keep their values.
- R3: After `start`, the receiver takes in L enabled bits, where L is 6, 9, 11 or 12 for codes 0 to 3. It then checks the following bits against its prediction. `inSync` rises at the clock edge that takes the 32nd consecutive correct prediction, and not one bit sooner.
- R4: A wrong prediction before lock restarts the count of loaded bits from the next enabled bit. Lock then needs another L loaded bits and 32 correct predictions.
- R5: While `inSync` is high, each enabled bit adds one to `bitCount`. Each enabled bit that differs from the locally extended reference also adds one to `errCount`. A single corrupted bit counts as exactly one error, because the reference does not take in received bits while locked.
- R6: While `inSync` is low, `bitCount` and `errCount` do not change, except when `start` clears them.
- R7: Error density is judged in blocks of 64 compared bits, counted from the moment of lock. The 8th error inside one block drops `inSync` at that bit's edge, and that bit is still counted. Seven errors in a block keep lock, even if the next block begins with seven more.
- R8: Both counters stop at their all-ones value instead of wrapping.
- R9: `start` sets both counters to zero, drops `inSync`, reseeds both generators and begins acquisition.
- R10: After reset, `inSync` is low and both counters are zero. They stay that way, whatever arrives on `rxBit`, until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start/clear pulse; captures `patSel` |
| patSel | input | 2 | Pattern code 0..3 (lengths 63, 511, 2047, 4095) |
| bitEn | input | 1 | One bit is transferred in each cycle this is high |
| rxBit | input | 1 | Received bit, sampled when `bitEn` is high |
| txBit | output | 1 | Transmitted bit, valid for the current enabled cycle |
| inSync | output | 1 | High while the receiver is locked |
| bitCount | output | CNT_W (32) | Saturating count of bits received while locked |
| errCount | output | CNT_W (32) | Saturating count of errored bits received while locked |

## Verification
Suppose the reference register were misaligned or took in received bits while locked. Then a single injected error would turn into a burst or into a steady stream of mismatches. That shows up at the ports within one 64-bit block, either as an error count larger than the number of bits corrupted or as `inSync` dropping. A wrong count in the acquisition or block counters moves the lock or loss edge by whole bits, so the bench checks `inSync` one bit before and at the expected bit. A tap error shows up within about a dozen transmitted bits as a broken recurrence on `txBit`.

// File: rtl/pn_bert_pkg.sv
package pn_bert_pkg;

  localparam int GEN_W = 12;
  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_VERIFY,
    ST_SYNC
  } bertState_t;

  // strobes from control to datapath, already qualified by the bit strobe
  typedef struct packed {
    logic seed;
    logic txAdv;
    logic refLoad;
    logic refAdv;
    logic count;
  } bertCtl_t;

  // feedback taps, bit k holds the bit received k+1 steps ago
  function automatic logic [GEN_W-1:0] tapMask(input logic [1:0] code);
    case (code)
      2'd0:    tapMask = 12'h030;
      2'd1:    tapMask = 12'h110;
      2'd2:    tapMask = 12'h500;
      default: tapMask = 12'h829;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] regLen(input logic [1:0] code);
    case (code)
      2'd0:    regLen = 4'd6;
      2'd1:    regLen = 4'd9;
      2'd2:    regLen = 4'd11;
      default: regLen = 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/pn_gen.sv
module pn_gen
  import pn_bert_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             seed,
  input  logic             shift,
  input  logic             useExt,
  input  logic             extBit,
  input  logic [GEN_W-1:0] mask,
  output logic             fbBit
);

  logic [GEN_W-1:0] shiftReg;

  assign fbBit = ^(shiftReg & mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (seed) begin
      shiftReg <= '1;
    end else if (shift) begin
      shiftReg <= {shiftReg[GEN_W-2:0], (useExt ? extBit : fbBit)};
    end
  end

endmodule

// File: rtl/pn_bert_ctrl.sv
module pn_bert_ctrl
  import pn_bert_pkg::*;
#(
  parameter int SYNC_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int WIN_ERR  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] patSel,
  input  logic       bitEn,
  input  logic       mismatch,
  output bertCtl_t   ctl,
  output logic [1:0] pat,
  output logic       inSync
);

  localparam int RUN_W  = $clog2(SYNC_RUN + 1);
  localparam int WPOS_W = $clog2(WIN_LEN);
  localparam int WERR_W = $clog2(WIN_ERR + 1);

  bertState_t        state;
  logic [LEN_W-1:0]  loadCnt;
  logic [RUN_W-1:0]  runCnt;
  logic [WPOS_W-1:0] winPos;
  logic [WERR_W-1:0] winErr;
  logic              stepBit;

  assign stepBit = bitEn && !start;
  assign inSync  = (state == ST_SYNC);

  always_comb begin
    ctl.seed    = start;
    ctl.txAdv   = stepBit;
    ctl.refLoad = stepBit && (state == ST_LOAD);
    ctl.refAdv  = stepBit && ((state == ST_VERIFY) || (state == ST_SYNC));
    ctl.count   = stepBit && (state == ST_SYNC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pat     <= 2'd0;
      loadCnt <= '0;
      runCnt  <= '0;
      winPos  <= '0;
      winErr  <= '0;
    end else if (start) begin
      state   <= ST_LOAD;
      pat     <= patSel;
      loadCnt <= '0;
      runCnt  <= '0;
      winPos  <= '0;
      winErr  <= '0;
    end else if (bitEn) begin
      case (state)
        ST_LOAD: begin
          if (loadCnt == regLen(pat) - 4'd1) begin
            state  <= ST_VERIFY;
            runCnt <= '0;
          end else begin
            loadCnt <= loadCnt + 4'd1;
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            state   <= ST_LOAD;
            loadCnt <= '0;
          end else if (runCnt == RUN_W'(SYNC_RUN - 1)) begin
            state  <= ST_SYNC;
            winPos <= '0;
            winErr <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (mismatch && (winErr == WERR_W'(WIN_ERR - 1))) begin
            state   <= ST_LOAD;
            loadCnt <= '0;
          end else if (winPos == WPOS_W'(WIN_LEN - 1)) begin
            winPos <= '0;
            winErr <= '0;
          end else begin
            winPos <= winPos + 1'b1;
            winErr <= winErr + WERR_W'(mismatch);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pn_bert_dp.sv
module pn_bert_dp
  import pn_bert_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  bertCtl_t         ctl,
  input  logic [1:0]       pat,
  input  logic             rxBit,
  output logic             txBit,
  output logic             mismatch,
  output logic [CNT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount
);

  logic [GEN_W-1:0] mask;
  logic             refBit;

  assign mask     = tapMask(pat);
  assign mismatch = rxBit ^ refBit;

  pn_gen txGen_i (
    .clk    (clk),
    .rstN   (rstN),
    .seed   (ctl.seed),
    .shift  (ctl.txAdv),
    .useExt (1'b0),
    .extBit (1'b0),
    .mask   (mask),
    .fbBit  (txBit)
  );

  pn_gen refGen_i (
    .clk    (clk),
    .rstN   (rstN),
    .seed   (ctl.seed),
    .shift  (ctl.refLoad || ctl.refAdv),
    .useExt (ctl.refLoad),
    .extBit (rxBit),
    .mask   (mask),
    .fbBit  (refBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      errCount <= '0;
    end else if (ctl.seed) begin
      bitCount <= '0;
      errCount <= '0;
    end else if (ctl.count) begin
      if (bitCount != '1) bitCount <= bitCount + 1'b1;
      if (mismatch && (errCount != '1)) errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/pn_bert.sv
module pn_bert
  import pn_bert_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int WIN_ERR  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       patSel,
  input  logic             bitEn,
  input  logic             rxBit,
  output logic             txBit,
  output logic             inSync,
  output logic [CNT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount
);

  bertCtl_t   ctl;
  logic [1:0] pat;
  logic       mismatch;

  pn_bert_ctrl #(
    .SYNC_RUN (SYNC_RUN),
    .WIN_LEN  (WIN_LEN),
    .WIN_ERR  (WIN_ERR)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .patSel   (patSel),
    .bitEn    (bitEn),
    .mismatch (mismatch),
    .ctl      (ctl),
    .pat      (pat),
    .inSync   (inSync)
  );

  pn_bert_dp #(
    .CNT_W (CNT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pat      (pat),
    .rxBit    (rxBit),
    .txBit    (txBit),
    .mismatch (mismatch),
    .bitCount (bitCount),
    .errCount (errCount)
  );

endmodule

// File: rtl/pn_bert_chk.sv
module pn_bert_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             bitEn,
  input logic             txBit,
  input logic             inSync,
  input logic [CNT_W-1:0] bitCount,
  input logic [CNT_W-1:0] errCount
);

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (bitCount == '0 && errCount == '0 && !inSync));

  assert_frozen_unlocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!inSync && !start) |=> ($stable(bitCount) && $stable(errCount)));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !start) |=> ($stable(txBit) && $stable(inSync) &&
                            $stable(bitCount) && $stable(errCount)));

  assert_err_not_above_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= bitCount);

  assert_bits_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount == '1 && !start) |=> bitCount == '1);

  assert_errs_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == '1 && !start) |=> errCount == '1);

  assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(bitEn));

endmodule

bind pn_bert pn_bert_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .bitEn    (bitEn),
  .txBit    (txBit),
  .inSync   (inSync),
  .bitCount (bitCount),
  .errCount (errCount)
);

// File: tb/pn_bert_tb_top.sv
module pn_bert_tb_top;

  localparam int CW = 10;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    patSel = 2'd0;
  logic          bitEn = 1'b0;
  logic          rxBit = 1'b0;
  logic          txBit;
  logic          inSync;
  logic [CW-1:0] bitCount;
  logic [CW-1:0] errCount;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  logic [1:0]  curPat = 2'd0;
  logic [11:0] rxHist = 12'h3A7;
  logic [11:0] txHist = 12'h000;
  int txCnt = 0;
  int txBad = 0;
  int txOnes = 0;

  always #2.5 clk = ~clk;

  pn_bert #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .patSel(patSel), .bitEn(bitEn),
    .rxBit(rxBit), .txBit(txBit), .inSync(inSync),
    .bitCount(bitCount), .errCount(errCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic tapBit(input logic [1:0] p, input logic [11:0] h);
    case (p)
      2'd0:    return h[5] ^ h[4];
      2'd1:    return h[8] ^ h[4];
      2'd2:    return h[10] ^ h[8];
      default: return h[11] ^ h[5] ^ h[3] ^ h[0];
    endcase
  endfunction

  function automatic int patLen(input logic [1:0] p);
    case (p)
      2'd0: return 6;
      2'd1: return 9;
      2'd2: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic bit errAt(input int mode, input int i);
    case (mode)
      1: return (i == 5) || (i == 40) || (i == 70);
      2: return (i >= 57 && i <= 70) || (i >= 128 && i <= 135);
      3: return (i % 64) < 7;
      default: return 1'b0;
    endcase
  endfunction

  task automatic stepBit(input bit err);
    logic b;
    @(negedge clk);
    b = tapBit(curPat, rxHist);
    rxHist = {rxHist[10:0], b};
    rxBit = b ^ err;
    bitEn = 1'b1;
    if (txCnt >= 12 && txBit !== tapBit(curPat, txHist)) txBad++;
    if (txBit) txOnes++;
    txHist = {txHist[10:0], txBit};
    txCnt++;
  endtask

  task automatic sendBits(input int n, input int mode, input int base);
    for (int i = 0; i < n; i++) stepBit(errAt(mode, base + i));
  endtask

  task automatic settle();
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic doStart(input logic [1:0] p);
    @(negedge clk);
    bitEn = 1'b0;
    start = 1'b1;
    patSel = p;
    @(negedge clk);
    start = 1'b0;
    patSel = ~p;   // must be ignored after capture (R1)
    curPat = p;
    txCnt = 0; txBad = 0; txOnes = 0;
    txHist = 12'h000;
    rxHist = 12'h3A7;
  endtask

  task automatic acquire(input int len);
    sendBits(len + 31, 0, 0);
    settle();
    chk(inSync == 1'b0, "R3 no lock one bit early", inSync, 0);
    sendBits(1, 0, 0);
    settle();
    chk(inSync == 1'b1, "R3 lock at 32nd match", inSync, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic t0;
    logic [CW-1:0] b0, e0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state and idle before start
    chk(inSync == 1'b0, "R10 reset inSync", inSync, 0);
    chk(bitCount == 0 && errCount == 0, "R10 reset counters", bitCount + errCount, 0);
    sendBits(60, 0, 0);
    settle();
    chk(inSync == 1'b0 && bitCount == 0, "R10 no lock before start", bitCount + inSync, 0);

    // R1 R3 R5 R2 per pattern
    for (int p = 0; p < 4; p++) begin
      doStart(2'(p));
      chk(bitCount == 0 && !inSync, "R9 start state", bitCount + inSync, 0);
      acquire(patLen(2'(p)));
      chk(bitCount == 0 && errCount == 0, "R6 no counting during acquisition",
          bitCount + errCount, 0);
      sendBits(50, 1, 0);
      settle();
      t0 = txBit; b0 = bitCount; e0 = errCount;
      repeat (4) @(negedge clk);
      chk(txBit == t0 && bitCount == b0 && errCount == e0 && inSync,
          "R2 hold without bitEn", bitCount, b0);
      sendBits(50, 1, 50);
      settle();
      chk(bitCount == 100, "R5 bit count", bitCount, 100);
      chk(errCount == 3, "R5 single errors counted once", errCount, 3);
      chk(txBad == 0 && txOnes > 0, "R1 transmit recurrence", txBad, 0);
    end

    // R4 error during verification restarts loading
    doStart(2'd2);
    sendBits(11 + 9, 0, 0);
    stepBit(1'b1);
    sendBits(11 + 31, 0, 0);
    settle();
    chk(inSync == 1'b0, "R4 relock not early", inSync, 0);
    sendBits(1, 0, 0);
    settle();
    chk(inSync == 1'b1, "R4 relock after reload", inSync, 1);
    chk(bitCount == 0, "R4 nothing counted before lock", bitCount, 0);

    // R7 block-aligned loss window, R6 frozen while hunting
    doStart(2'd1);
    acquire(9);
    sendBits(128, 2, 0);
    settle();
    chk(inSync == 1'b1, "R7 seven per block keeps lock", inSync, 1);
    chk(bitCount == 128 && errCount == 14, "R7 counts across blocks", errCount, 14);
    sendBits(7, 2, 128);
    settle();
    chk(inSync == 1'b1, "R7 seven errors in block", inSync, 1);
    sendBits(1, 2, 135);
    settle();
    chk(inSync == 1'b0, "R7 eighth error drops lock", inSync, 0);
    chk(bitCount == 136 && errCount == 22, "R7 losing bit counted", bitCount, 136);
    sendBits(40, 0, 0);
    settle();
    chk(inSync == 1'b0 && bitCount == 136 && errCount == 22, "R6 frozen while hunting",
        errCount, 22);
    sendBits(1, 0, 0);
    settle();
    chk(inSync == 1'b1, "R7 reacquired", inSync, 1);
    chk(bitCount == 136, "R6 counters kept over reacquisition", bitCount, 136);

    // R8 saturation
    doStart(2'd0);
    acquire(6);
    sendBits(1023, 3, 0);
    settle();
    chk(bitCount == MAXC, "R8 bit count reaches max", bitCount, MAXC);
    chk(errCount == 112, "R8 error count before max", errCount, 112);
    sendBits(9000, 3, 1023);
    settle();
    chk(bitCount == MAXC, "R8 bit count saturates", bitCount, MAXC);
    chk(errCount == MAXC, "R8 error count saturates", errCount, MAXC);
    chk(inSync == 1'b1, "R7 lock held at seven per block", inSync, 1);

    // R9 start clears
    doStart(2'd3);
    chk(bitCount == 0 && errCount == 0, "R9 start clears counters", bitCount + errCount, 0);
    chk(inSync == 1'b0, "R9 start drops lock", inSync, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule